// File: doc/BRIEF.md
# Prescaled Up/Down Timer with Toggle Latch

This block is a general purpose up/down counter, 16 bits wide by default. It counts one of two things. The first is ticks from an internal prescaler that divides the system clock by 4 × 2^code. The second is qualified edges on an external count pin. A software bit selects the count direction. When enabled, a direction pin can invert that choice on the fly. A gated variant counts prescaled ticks only while a gate pin sits at a chosen level.

A wrap happens when the counter goes up from all-ones to zero or down from zero to all-ones. Each wrap does three things in the same clock edge:
- it flips an output toggle latch, which can drive a port pin or clock a neighbouring timer;
- it may replace the wrapped value with an externally supplied reload value;
- it raises a one-cycle cascade pulse together with a one-cycle interrupt request.

All outputs come straight from registers. The external pins pass through a two-stage synchronizer before they are used.

Top module: `updown_timer`

## Requirements
- R1: After synchronous reset, `count` is 0, and `tgl_out`, `ovf_pulse` and `irq` are all 0.
- R2: In timer mode (`mode`=00) with `run` high, the counter steps once every 4 × 2^`pre_code` clock cycles. The prescaler restarts from zero whenever `run` is low, so the first step lands on the (4 × 2^`pre_code`)-th edge at which `run` is high.
- R3: While `run` is low, or `mode`=11, the counter never steps. During that time `ovf_pulse` and `irq` stay low and `tgl_out` does not change.
- R4: The count goes down when `sw_down` XOR (`ext_dir_en` AND synchronized `dir_pin`) is 1, and up otherwise. When `ext_dir_en` is 0, `dir_pin` has no effect.
- R5: Counting up from 0xFFFF gives 0x0000 (overflow). Counting down from 0x0000 gives 0xFFFF (underflow). Each such wrap inverts `tgl_out` at the same edge.
- R6: When `reload_en` is 1 at a wrapping edge, `count` takes `reload_val` instead of the wrapped value at that edge.
- R7: `ovf_pulse` and `irq` are high for exactly the one cycle that follows each wrapping edge. They are low otherwise.
- R8: In gated mode (`mode`=01), prescaled ticks are counted only while the synchronized `gate_pin` equals `gate_lvl`.
- R9: In counter mode (`mode`=10), the counter steps on edges of the synchronized `cnt_pin`. `edge_sel` chooses which edges: 01 rising, 10 falling, 11 both, 00 none.
- R10: `wr_en` loads `wr_val` into the counter at the next edge. A load takes priority over a step and never toggles the latch or pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables counting and the prescaler |
| mode | input | 2 | 00 timer, 01 gated, 10 counter, 11 stopped |
| pre_code | input | 3 | Prescale code, divide by 4 × 2^code |
| sw_down | input | 1 | Software direction, 1 = down |
| ext_dir_en | input | 1 | Lets `dir_pin` invert the direction |
| gate_lvl | input | 1 | Active level of `gate_pin` in gated mode |
| edge_sel | input | 2 | Counter-mode edge choice |
| reload_en | input | 1 | Reload on wrap |
| reload_val | input | 16 | Value loaded on wrap |
| wr_en | input | 1 | Direct counter load strobe |
| wr_val | input | 16 | Value for direct load |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| dir_pin | input | 1 | External direction pin (asynchronous) |
| gate_pin | input | 1 | External gate pin (asynchronous) |
| count | output | 16 | Current counter value |
| tgl_out | output | 1 | Output toggle latch |
| ovf_pulse | output | 1 | One-cycle cascade pulse on wrap |
| irq | output | 1 | One-cycle interrupt request on wrap |

## Verification
The bench builds the block with its default 16-bit counter, 3-bit prescale code and two synchronizer stages. It uses direct loads near 0xFFFF and 0x0000, so wraps in both directions, reloads and toggle flips come within a few cycles instead of 65536. Every prescale code from ÷4 up to ÷512 is swept, and the larger codes still fit easily within the run length. Random pin activity in every mode is checked cycle by cycle against a reference model.

// File: rtl/utm_pkg.sv
package utm_pkg;
  typedef enum logic [1:0] {
    MD_TIMER   = 2'b00,
    MD_GATED   = 2'b01,
    MD_COUNTER = 2'b10,
    MD_STOP    = 2'b11
  } mode_e;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/utm_sync.sv
module utm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/utm_prescaler.sv
module utm_prescaler #(
  parameter int BASE_LOG2 = 2,
  parameter int CODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PRE_W = BASE_LOG2 + (1 << CODE_W) - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;

  // low (BASE_LOG2 + code) bits set
  assign mask = {PRE_W{1'b1}} >> (PRE_W - BASE_LOG2 - int'(code));
  assign tick = run && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + 1'b1;
  end

  // R2: divide factor is at least 2^BASE_LOG2, so ticks never sit back to back
  a_r2_tick_spaced: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/utm_event.sv
module utm_event
  import utm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] mode,
  input  logic [1:0] edge_sel,
  input  logic       gate_lvl,
  input  logic       sw_down,
  input  logic       ext_dir_en,
  input  logic       tick,
  input  logic       cnt_s,
  input  logic       dir_s,
  input  logic       gate_s,
  output logic       step,
  output logic       down
);
  mode_e md;
  logic  cnt_prev;
  logic  rise, fall, pin_evt;

  assign md = mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst) cnt_prev <= 1'b0;
    else     cnt_prev <= cnt_s;
  end

  assign rise    = cnt_s & ~cnt_prev;
  assign fall    = ~cnt_s & cnt_prev;
  assign pin_evt = (edge_sel[0] & rise) | (edge_sel[1] & fall);

  always_comb begin
    unique case (md)
      MD_TIMER:   step = run & tick;
      MD_GATED:   step = run & tick & (gate_s == gate_lvl);
      MD_COUNTER: step = run & pin_evt;
      default:    step = 1'b0;
    endcase
  end

  assign down = sw_down ^ (ext_dir_en & dir_s);
endmodule

// File: rtl/utm_counter.sv
module utm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          down,
  input  logic          reload_en,
  input  logic [CW-1:0] reload_val,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  output logic [CW-1:0] cnt,
  output logic          tgl,
  output logic          ovf,
  output logic          irq
);
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

  logic          wrap;
  logic [CW-1:0] nxt;

  assign wrap = down ? (cnt == '0) : (cnt == ALL1);
  assign nxt  = down ? cnt - 1'b1 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tgl <= 1'b0;
      ovf <= 1'b0;
      irq <= 1'b0;
    end else begin
      ovf <= 1'b0;
      irq <= 1'b0;
      if (wr_en) begin
        cnt <= wr_val;
      end else if (step) begin
        if (wrap) begin
          cnt <= reload_en ? reload_val : nxt;
          tgl <= ~tgl;
          ovf <= 1'b1;
          irq <= 1'b1;
        end else begin
          cnt <= nxt;
        end
      end
    end
  end

  // R5: every cascade pulse accompanies a latch flip
  a_r5_toggle_on_wrap: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (tgl != $past(tgl)));
  // R5: without reload the wrapped value is the opposite extreme
  a_r5_wrap_value: assert property (@(posedge clk) disable iff (rst)
    (ovf && !$past(reload_en)) |-> (cnt == '0 || cnt == ALL1));
  // R6: reload replaces the wrapped value
  a_r6_reload_value: assert property (@(posedge clk) disable iff (rst)
    (ovf && $past(reload_en)) |-> (cnt == $past(reload_val)));
  // R10: a load never produces a pulse
  a_r10_load_quiet: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !ovf);
endmodule

// File: rtl/updown_timer.sv
module updown_timer #(
  parameter int CW          = 16,
  parameter int CODE_W      = 3,
  parameter int BASE_LOG2   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] pre_code,
  input  logic              sw_down,
  input  logic              ext_dir_en,
  input  logic              gate_lvl,
  input  logic [1:0]        edge_sel,
  input  logic              reload_en,
  input  logic [CW-1:0]     reload_val,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_val,
  input  logic              cnt_pin,
  input  logic              dir_pin,
  input  logic              gate_pin,
  output logic [CW-1:0]     count,
  output logic              tgl_out,
  output logic              ovf_pulse,
  output logic              irq
);
  logic [2:0] pins_s;
  logic       tick, step, down;

  utm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({gate_pin, dir_pin, cnt_pin}),
    .q(pins_s)
  );

  utm_prescaler #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .code(pre_code), .tick(tick)
  );

  utm_event u_evt (
    .clk(clk), .rst(rst), .run(run), .mode(mode), .edge_sel(edge_sel),
    .gate_lvl(gate_lvl), .sw_down(sw_down), .ext_dir_en(ext_dir_en),
    .tick(tick), .cnt_s(pins_s[0]), .dir_s(pins_s[1]), .gate_s(pins_s[2]),
    .step(step), .down(down)
  );

  utm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .down(down),
    .reload_en(reload_en), .reload_val(reload_val),
    .wr_en(wr_en), .wr_val(wr_val),
    .cnt(count), .tgl(tgl_out), .ovf(ovf_pulse), .irq(irq)
  );

  // R3: with run low and no load the counter holds
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(count));
  // R3: no interrupt request follows an edge with run low
  a_r3_no_irq_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |=> !irq);
  // R7: interrupt and cascade pulse coincide
  a_r7_irq_with_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovf_pulse);
endmodule

// File: tb/tb_updown_timer.sv
module tb_updown_timer;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst;
  logic run, sw_down, ext_dir_en, gate_lvl, reload_en, wr_en;
  logic cnt_pin, dir_pin, gate_pin;
  logic [1:0] mode, edge_sel;
  logic [2:0] pre_code;
  logic [CW-1:0] reload_val, wr_val;
  logic [CW-1:0] count;
  logic tgl_out, ovf_pulse, irq;

  always #4 clk = ~clk;  // 125 MHz

  updown_timer dut (
    .clk(clk), .rst(rst), .run(run), .mode(mode), .pre_code(pre_code),
    .sw_down(sw_down), .ext_dir_en(ext_dir_en), .gate_lvl(gate_lvl),
    .edge_sel(edge_sel), .reload_en(reload_en), .reload_val(reload_val),
    .wr_en(wr_en), .wr_val(wr_val), .cnt_pin(cnt_pin), .dir_pin(dir_pin),
    .gate_pin(gate_pin), .count(count), .tgl_out(tgl_out),
    .ovf_pulse(ovf_pulse), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  string cur_req = "R1";

  // ---------------- reference model built from the requirements --------------
  logic [CW-1:0] m_cnt;
  logic m_tgl, m_ovf, m_irq;
  logic [8:0] m_pre;
  logic [1:0] m_cs, m_ds, m_gs;
  logic m_cprev;

  function automatic int div_of(input logic [2:0] c);
    return 4 << c;
  endfunction

  function automatic logic is_tick(input logic [8:0] p, input logic [2:0] c);
    return ((int'(p) % div_of(c)) == div_of(c) - 1);
  endfunction

  always @(posedge clk) begin
    logic stp, dn, ev, wr;
    logic [CW-1:0] nx;
    if (rst) begin
      m_cnt <= '0; m_tgl <= 0; m_ovf <= 0; m_irq <= 0;
      m_pre <= '0; m_cs <= '0; m_ds <= '0; m_gs <= '0; m_cprev <= 0;
    end else begin
      cyc <= cyc + 1;
      m_cs <= {m_cs[0], cnt_pin};
      m_ds <= {m_ds[0], dir_pin};
      m_gs <= {m_gs[0], gate_pin};
      m_cprev <= m_cs[1];
      m_pre <= run ? m_pre + 1'b1 : '0;
      ev = (edge_sel[0] && m_cs[1] && !m_cprev) || (edge_sel[1] && !m_cs[1] && m_cprev);
      case (mode)
        2'b00: stp = run && is_tick(m_pre, pre_code);
        2'b01: stp = run && is_tick(m_pre, pre_code) && (m_gs[1] == gate_lvl);
        2'b10: stp = run && ev;
        default: stp = 1'b0;
      endcase
      dn = sw_down ^ (ext_dir_en & m_ds[1]);
      m_ovf <= 0; m_irq <= 0;
      if (wr_en) m_cnt <= wr_val;
      else if (stp) begin
        wr = dn ? (m_cnt == 0) : (m_cnt == '1);
        nx = dn ? m_cnt - 1'b1 : m_cnt + 1'b1;
        if (wr) begin
          m_tgl <= ~m_tgl; m_ovf <= 1; m_irq <= 1;
          if (reload_en) nx = reload_val;
        end
        m_cnt <= nx;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(cur_req, 64'(count), 64'(m_cnt), "count");
    check(cur_req, 64'(tgl_out), 64'(m_tgl), "tgl_out");
    check(cur_req, 64'(ovf_pulse), 64'(m_ovf), "ovf_pulse");
    check(cur_req, 64'(irq), 64'(m_irq), "irq");
  endtask

  // one clock, compare away from the edge
  task automatic step1();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step1();
  endtask

  task automatic load(input logic [CW-1:0] v);
    wr_en = 1; wr_val = v;
    step1();
    wr_en = 0;
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] c0;
    void'($urandom(32'd1234));
    rst = 1; run = 0; mode = 2'b00; pre_code = 0; sw_down = 0; ext_dir_en = 0;
    gate_lvl = 1; edge_sel = 2'b01; reload_en = 0; reload_val = '0;
    wr_en = 0; wr_val = '0; cnt_pin = 0; dir_pin = 0; gate_pin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    check("R1", 64'(count), 64'h0, "count after reset");
    check("R1", 64'({tgl_out, ovf_pulse, irq}), 64'h0, "flags after reset");
    rst = 0;
    steps(2);

    // R2 each prescale code, directed exact step timing
    cur_req = "R2";
    for (int c = 0; c < 8; c++) begin
      run = 0; pre_code = 3'(c); steps(1);
      load('0);
      run = 1;
      steps(div_of(3'(c)) - 1);
      check("R2", 64'(count), 64'h0, "count before first tick");
      steps(1);
      check("R2", 64'(count), 64'h1, "count at first tick");
      steps(div_of(3'(c)) * 2);
      check("R2", 64'(count), 64'h3, "count after three ticks");
    end

    // R3 run low and mode 11 hold everything
    cur_req = "R3";
    pre_code = 0;
    load(16'hFFFF);
    run = 0;
    for (int i = 0; i < 40; i++) begin cnt_pin = ~cnt_pin; step1(); end
    check("R3", 64'(count), 64'hFFFF, "count held with run low");
    run = 1; mode = 2'b11;
    steps(40);
    check("R3", 64'(count), 64'hFFFF, "count held in mode 11");
    mode = 2'b00;

    // R4 direction pin ignored unless enabled, inverts when enabled
    cur_req = "R4";
    load(16'h0100);
    dir_pin = 1; ext_dir_en = 0; sw_down = 0;
    steps(40);
    check("R4", 64'(count > 16'h0100), 64'h1, "up with pin ignored");
    ext_dir_en = 1;
    c0 = count;
    steps(40);
    check("R4", 64'(count < c0), 64'h1, "down when pin inverts");
    sw_down = 1; dir_pin = 0;
    steps(20);

    // R5 R7 underflow then overflow, toggle and pulses
    cur_req = "R5 R7";
    ext_dir_en = 0; sw_down = 1;
    load(16'h0001);
    steps(12);
    sw_down = 0;
    load(16'hFFFE);
    steps(12);

    // R6 reload on wrap
    cur_req = "R6";
    reload_en = 1; reload_val = 16'h1234;
    load(16'hFFFE);
    steps(12);
    check("R6", 64'(count), 64'h1235, "count after reload then step");
    sw_down = 1; reload_val = 16'hABCD;
    load(16'h0000);
    steps(5);
    reload_en = 0; sw_down = 0;

    // R10 load priority and no toggle
    cur_req = "R10";
    load(16'hFFFF);
    run = 1;
    for (int i = 0; i < 12; i++) begin
      wr_en = 1; wr_val = 16'hFFFF; step1();
    end
    wr_en = 0;
    check("R10", 64'(count), 64'hFFFF, "load wins over step");

    // R8 gated mode
    cur_req = "R8";
    mode = 2'b01;
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 15) == 0) gate_pin = ~gate_pin;
      if (i == 300) gate_lvl = 0;
      step1();
    end

    // R9 counter mode with each edge choice
    cur_req = "R9";
    mode = 2'b10;
    for (int e = 0; e < 4; e++) begin
      edge_sel = 2'(e);
      load(16'hFFF8);
      for (int i = 0; i < 150; i++) begin
        if ($urandom_range(0, 2) == 0) cnt_pin = ~cnt_pin;
        step1();
      end
    end

    // mixed random
    cur_req = "R4 R5 R6 R7";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 63) == 0) mode = 2'($urandom);
      if ($urandom_range(0, 63) == 0) pre_code = 3'($urandom_range(0, 2));
      if ($urandom_range(0, 31) == 0) run = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 31) == 0) sw_down = 1'($urandom);
      if ($urandom_range(0, 31) == 0) ext_dir_en = 1'($urandom);
      if ($urandom_range(0, 31) == 0) reload_en = 1'($urandom);
      if ($urandom_range(0, 31) == 0) reload_val = 16'($urandom);
      if ($urandom_range(0, 31) == 0) edge_sel = 2'($urandom);
      if ($urandom_range(0, 63) == 0) gate_lvl = 1'($urandom);
      cnt_pin  = ($urandom_range(0, 2) == 0) ? ~cnt_pin : cnt_pin;
      if ($urandom_range(0, 15) == 0) dir_pin = ~dir_pin;
      if ($urandom_range(0, 15) == 0) gate_pin = ~gate_pin;
      wr_en = ($urandom_range(0, 99) == 0);
      wr_val = $urandom_range(0, 1) ? 16'(16'hFFF0 + $urandom_range(0, 15))
                                    : 16'($urandom_range(0, 15));
      step1();
    end
    wr_en = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule